// File: doc/BRIEF.md
# Clock Output Gating and Power-Down Controller

This block sits between a set of internally generated clocks and the output pins they drive. Each output is a copy of its own source clock, opened or closed by a gate that only changes state while the source is low, so an output never produces a shortened pulse. A per-output enable vector from a configuration register chooses which outputs run. A global high-impedance bit and a global spread-enable flag are carried into the output domain through a two-stage synchroniser.

An active-low power-down request arrives asynchronously. The block brings it into the CPU clock domain through two flops. It acts on the request only after the synchronised value has been low on two CPU-clock rising edges in a row. Every output then parks low at its own next falling edge. Once all outputs are parked, the block raises a stop request for the oscillator and PLL. When the request has been high on two rising edges in a row, the stop request drops. A settle count covers the restart time of the oscillator and PLL. After that count the outputs are released one per CPU cycle, in ascending index order.

All pins are plain control and clock signals. No data stream passes through the block, so there is no valid/ready handshake and no back-pressure. The source clocks are assumed to come from the same PLL as the CPU clock, so they are phase-related to it.

Top module: `clkout_park_ctrl`

## Requirements
- R1: While `rst_n` is low, every `clk_out` bit, `osc_stop`, `out_hiz` and `spread_en` are 0. After reset, the release mask is full, so every output whose enable bit is 1 starts running at the first falling edge of its source.
- R2: A request is acted on only when the synchronised `pd_req_n` is 0 on two consecutive `clk_cpu` rising edges. A low pulse that covers a single rising edge has no effect: `osc_stop` stays 0 and the outputs keep running.
- R3: `clk_out[i]` equals `src_clk[i]` while its gate is open. The gate opens or closes only on a falling edge of `src_clk[i]`, so `clk_out[i]` is never high while `src_clk[i]` is low and no high pulse is cut short.
- R4: Power-down is qualified at the edge that sees the second low sample; a request driven low just after edge E is qualified at edge E+4. `osc_stop` rises only after every output has parked, and while it is 1 all `clk_out` bits are 0. It falls at the fourth rising edge after `pd_req_n` returns high.
- R5: When bit i of `out_en` is 0, `clk_out[i]` is held low from the next falling edge of `src_clk[i]` onward. Bit i of `out_en` controls `clk_out[i]`.
- R6: `out_hiz` follows `hiz_cfg` (1 means the pins are to be high impedance), and `spread_en` follows `spread_cfg`. Each output equals its input as sampled two rising edges earlier.
- R7: After `osc_stop` falls, the block waits `SETTLE_CYC` CPU cycles in the settle state. It then sets release-mask bits 0, 1, 2 and so on, one per cycle, and each output opens at the first falling edge of its source after its bit is set.
- R8: A qualified power-down during the settle count or the release sequence clears the whole release mask at once. The outputs park again and `osc_stop` rises again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_cpu | input | 1 | CPU clock; domain of the control logic |
| rst_n | input | 1 | Asynchronous active-low reset |
| pd_req_n | input | 1 | Asynchronous active-low power-down request |
| src_clk | input | N_OUT | Internally generated source clocks, one per output |
| out_en | input | N_OUT | Per-output enable from the configuration register (1 = run) |
| hiz_cfg | input | 1 | Global high-impedance control (1 = float all outputs) |
| spread_cfg | input | 1 | Global spread-spectrum enable flag |
| clk_out | output | N_OUT | Gated output clocks |
| out_hiz | output | 1 | Synchronised high-impedance control for the pad drivers |
| spread_en | output | 1 | Synchronised spread-enable flag |
| osc_stop | output | 1 | Request to stop the oscillator and PLL |

## Verification
Two situations put two functions in the same cycle.

The first is a power-down qualification that lands while the release sequence is still setting mask bits. The bench drops `pd_req_n` ten cycles after the wake-up edge. Qualification then happens in the middle of the release sequence. The reference model expects the abort to win: no further mask bit is set, and every output parks at its own next falling edge.

The second is an enable bit that changes while other outputs are running. Here the output must close only at its own falling edge. The model predicts the gate state at every falling edge from the requirements, and the outputs are compared to it on both clock phases.

// File: rtl/clkpark_pkg.sv
package clkpark_pkg;

  typedef enum logic [2:0] {
    PS_RUN    = 3'd0,
    PS_DRAIN  = 3'd1,
    PS_OFF    = 3'd2,
    PS_SETTLE = 3'd3,
    PS_RAMP   = 3'd4
  } park_state_e;

  function automatic int unsigned idx_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/clkpark_sync.sv
module clkpark_sync #(
  parameter int unsigned W       = 1,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= {W{RST_VAL}};
      q      <= {W{RST_VAL}};
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end

endmodule

// File: rtl/clkpark_seq.sv
module clkpark_seq
  import clkpark_pkg::*;
#(
  parameter int unsigned N_OUT      = 4,
  parameter int unsigned SETTLE_CYC = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_n_sync,
  input  logic [N_OUT-1:0] parked,
  output logic [N_OUT-1:0] rel_mask,
  output logic             osc_stop
);

  localparam int unsigned CNT_W = $clog2(SETTLE_CYC + 1);
  localparam int unsigned IDX_W = idx_width(N_OUT);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SETTLE_CYC - 1);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(N_OUT - 1);

  park_state_e      state;
  logic             req_n_prev;
  logic             qual_lo;
  logic             qual_hi;
  logic             all_parked;
  logic [CNT_W-1:0] settle_cnt;
  logic [IDX_W-1:0] ramp_idx;

  // two consecutive synchronised samples agree
  assign qual_lo    = ~req_n_sync & ~req_n_prev;
  assign qual_hi    =  req_n_sync &  req_n_prev;
  assign all_parked = &parked;
  assign osc_stop   = (state == PS_OFF);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= PS_RUN;
      req_n_prev <= 1'b1;
      rel_mask   <= '1;
      settle_cnt <= '0;
      ramp_idx   <= '0;
    end else begin
      req_n_prev <= req_n_sync;
      unique case (state)
        PS_RUN: begin
          if (qual_lo) begin
            state    <= PS_DRAIN;
            rel_mask <= '0;
          end
        end
        PS_DRAIN: begin
          if (all_parked) state <= PS_OFF;
        end
        PS_OFF: begin
          if (qual_hi) begin
            state      <= PS_SETTLE;
            settle_cnt <= '0;
          end
        end
        PS_SETTLE: begin
          if (qual_lo) begin
            state <= PS_DRAIN;
          end else if (settle_cnt == CNT_LAST) begin
            state    <= PS_RAMP;
            ramp_idx <= '0;
          end else begin
            settle_cnt <= settle_cnt + 1'b1;
          end
        end
        PS_RAMP: begin
          if (qual_lo) begin
            state    <= PS_DRAIN;
            rel_mask <= '0;
          end else begin
            rel_mask[ramp_idx] <= 1'b1;
            if (ramp_idx == IDX_LAST) state <= PS_RUN;
            else                      ramp_idx <= ramp_idx + 1'b1;
          end
        end
        default: state <= PS_RUN;
      endcase
    end
  end

endmodule

// File: rtl/clkpark_gate.sv
module clkpark_gate (
  input  logic src,
  input  logic rst_n,
  input  logic allow,
  output logic out_clk,
  output logic parked
);

  logic open_q;

  // enable is captured only on the falling edge, while the source is low
  always_ff @(negedge src or negedge rst_n) begin
    if (!rst_n) open_q <= 1'b0;
    else        open_q <= allow;
  end

  assign out_clk = src & open_q;
  assign parked  = ~open_q;

endmodule

// File: rtl/clkout_park_ctrl.sv
module clkout_park_ctrl #(
  parameter int unsigned N_OUT      = 4,
  parameter int unsigned SETTLE_CYC = 16
) (
  input  logic             clk_cpu,
  input  logic             rst_n,
  input  logic             pd_req_n,
  input  logic [N_OUT-1:0] src_clk,
  input  logic [N_OUT-1:0] out_en,
  input  logic             hiz_cfg,
  input  logic             spread_cfg,
  output logic [N_OUT-1:0] clk_out,
  output logic             out_hiz,
  output logic             spread_en,
  output logic             osc_stop
);

  logic             req_n_sync;
  logic [N_OUT-1:0] rel_mask;
  logic [N_OUT-1:0] parked;
  logic [1:0]       cfg_sync;

  clkpark_sync #(.W(1), .RST_VAL(1'b1)) u_req_sync (
    .clk   (clk_cpu),
    .rst_n (rst_n),
    .d     (pd_req_n),
    .q     (req_n_sync)
  );

  clkpark_sync #(.W(2), .RST_VAL(1'b0)) u_cfg_sync (
    .clk   (clk_cpu),
    .rst_n (rst_n),
    .d     ({hiz_cfg, spread_cfg}),
    .q     (cfg_sync)
  );

  assign out_hiz   = cfg_sync[1];
  assign spread_en = cfg_sync[0];

  clkpark_seq #(.N_OUT(N_OUT), .SETTLE_CYC(SETTLE_CYC)) u_seq (
    .clk        (clk_cpu),
    .rst_n      (rst_n),
    .req_n_sync (req_n_sync),
    .parked     (parked),
    .rel_mask   (rel_mask),
    .osc_stop   (osc_stop)
  );

  for (genvar gi = 0; gi < N_OUT; gi++) begin : g_out
    clkpark_gate u_gate (
      .src     (src_clk[gi]),
      .rst_n   (rst_n),
      .allow   (rel_mask[gi] & out_en[gi]),
      .out_clk (clk_out[gi]),
      .parked  (parked[gi])
    );
  end

endmodule

// File: rtl/clkout_park_chk.sv
module clkout_park_chk #(
  parameter int unsigned N_OUT = 4
) (
  input logic             clk_cpu,
  input logic             rst_n,
  input logic             pd_req_n,
  input logic             hiz_cfg,
  input logic             spread_cfg,
  input logic [N_OUT-1:0] clk_out,
  input logic             osc_stop,
  input logic             out_hiz,
  input logic             spread_en,
  input logic [N_OUT-1:0] rel_mask
);

  AST_STOP_OUTPUTS_LOW: assert property (@(posedge clk_cpu) disable iff (!rst_n)
    osc_stop |-> (clk_out == '0)); // R4

  AST_WAKE_QUALIFIED: assert property (@(posedge clk_cpu) disable iff (!rst_n)
    $fell(osc_stop) |-> ($past(pd_req_n, 3) && $past(pd_req_n, 4))); // R4

  AST_HIZ_PASS: assert property (@(posedge clk_cpu) disable iff (!rst_n)
    out_hiz == $past(hiz_cfg, 2)); // R6

  AST_SPREAD_PASS: assert property (@(posedge clk_cpu) disable iff (!rst_n)
    spread_en == $past(spread_cfg, 2)); // R6

  AST_RAMP_ONE_STEP: assert property (@(posedge clk_cpu) disable iff (!rst_n)
    $onehot0(rel_mask & ~$past(rel_mask))); // R7

  AST_RAMP_IN_ORDER: assert property (@(posedge clk_cpu) disable iff (!rst_n)
    ((rel_mask + N_OUT'(1)) & rel_mask) == '0); // R7

endmodule

bind clkout_park_ctrl clkout_park_chk #(.N_OUT(N_OUT)) u_chk (
  .clk_cpu    (clk_cpu),
  .rst_n      (rst_n),
  .pd_req_n   (pd_req_n),
  .hiz_cfg    (hiz_cfg),
  .spread_cfg (spread_cfg),
  .clk_out    (clk_out),
  .osc_stop   (osc_stop),
  .out_hiz    (out_hiz),
  .spread_en  (spread_en),
  .rel_mask   (rel_mask)
);

// File: tb/clkout_park_ctrl_bench.sv
`timescale 1ns/1ps
module clkout_park_ctrl_bench;

  localparam int N  = 4;
  localparam int SC = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b1;
  logic         pd_req_n = 1'b1;
  logic         hiz_cfg = 1'b0;
  logic         spread_cfg = 1'b0;
  logic [N-1:0] out_en = '1;
  logic         s1 = 1'b0, s2 = 1'b0, s3 = 1'b1;
  logic [N-1:0] src_clk;
  logic [N-1:0] clk_out;
  logic         out_hiz, spread_en, osc_stop;

  int n_chk = 0;
  int n_err = 0;
  int cyc = 0;
  bit done = 0;

  assign src_clk = {s3, s2, s1, clk};

  always #10 clk = ~clk; // 50 MHz

  clkout_park_ctrl #(.N_OUT(N), .SETTLE_CYC(SC)) u_clkout_park_ctrl (
    .clk_cpu    (clk_cpu_w),
    .rst_n      (rst_n),
    .pd_req_n   (pd_req_n),
    .src_clk    (src_clk),
    .out_en     (out_en),
    .hiz_cfg    (hiz_cfg),
    .spread_cfg (spread_cfg),
    .clk_out    (clk_out),
    .out_hiz    (out_hiz),
    .spread_en  (spread_en),
    .osc_stop   (osc_stop)
  );
  wire clk_cpu_w = clk;

  // ---------------- reference model ----------------
  int           m_phase = 0; // 0 run, 1 drain, 2 off, 3 settle, 4 ramp
  int           m_cnt = 0;
  int           m_idx = 0;
  bit [N-1:0]   m_mask = '1;
  bit [N-1:0]   m_gate = '0;
  bit           hist[$] = '{1'b1, 1'b1, 1'b1};
  bit           m_hiz = 0, m_ss = 0, p_hiz = 0, p_ss = 0;
  bit           lo, hi;
  int           nc = 0;
  logic [N-1:0] old_src, new_src;
  logic         n1, n2, n3;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_phase = 0; m_mask = '1; m_cnt = 0; m_idx = 0;
      hist = '{1'b1, 1'b1, 1'b1};
      m_hiz = 0; m_ss = 0; p_hiz = 0; p_ss = 0;
    end else begin
      lo = !hist[1] && !hist[2];
      hi =  hist[1] &&  hist[2];
      case (m_phase)
        0: if (lo) begin m_phase = 1; m_mask = '0; end
        1: if (m_gate == '0) m_phase = 2;
        2: if (hi) begin m_phase = 3; m_cnt = 0; end
        3: if (lo) m_phase = 1;
           else if (m_cnt == SC - 1) begin m_phase = 4; m_idx = 0; end
           else m_cnt++;
        4: if (lo) begin m_phase = 1; m_mask = '0; end
           else begin
             m_mask[m_idx] = 1'b1;
             if (m_idx == N - 1) m_phase = 0; else m_idx++;
           end
        default: m_phase = 0;
      endcase
      hist.push_front(pd_req_n);
      void'(hist.pop_back());
      m_hiz = p_hiz; m_ss = p_ss;
      p_hiz = hiz_cfg; p_ss = spread_cfg;
    end
  end

  // source clocks change at the CPU falling edge; gates follow at source falls
  always @(negedge clk) begin
    old_src = {s3, s2, s1, 1'b1};
    nc++;
    n1 = ~s1;
    n2 = (nc % 2 == 0) ? ~s2 : s2;
    n3 = ~n1;
    new_src = {n3, n2, n1, 1'b0};
    for (int i = 0; i < N; i++) begin
      if (!rst_n) m_gate[i] = 1'b0;
      else if (old_src[i] && !new_src[i]) m_gate[i] = m_mask[i] & out_en[i];
    end
    s1 = n1; s2 = n2; s3 = n3;
  end

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic compare_all();
    chk("R3 R5", "clk_out", 32'(clk_out), 32'(src_clk & m_gate));
    chk("R4", "osc_stop", 32'(osc_stop), 32'(m_phase == 2));
    chk("R6", "out_hiz", 32'(out_hiz), 32'(m_hiz));
    chk("R6", "spread_en", 32'(spread_en), 32'(m_ss));
  endtask

  always @(posedge clk) begin #5; if (!done) compare_all(); end
  always @(negedge clk) begin #5; if (!done) compare_all(); end

  task automatic drive_slot(); @(posedge clk); #3; endtask
  task automatic sample_slot(); @(posedge clk); #5; endtask

  task automatic finish_run();
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      n_chk++; n_err++;
      $display("FAIL R1 watchdog: actual=%0d expected<=%0d cycles", cyc, 20000);
      finish_run();
    end
  end

  initial begin
    #1 rst_n = 1'b0;
    // R1: reset state
    sample_slot();
    chk("R1", "clk_out in reset", 32'(clk_out), 32'h0);
    chk("R1", "osc_stop in reset", 32'(osc_stop), 32'h0);
    chk("R1", "out_hiz in reset", 32'(out_hiz), 32'h0);
    chk("R1", "spread_en in reset", 32'(spread_en), 32'h0);
    drive_slot(); rst_n = 1'b1;
    repeat (20) sample_slot();
    chk("R1", "clk_out[0] running after reset", 32'(clk_out[0]), 32'h1);

    // R2: single-edge low pulse is ignored
    drive_slot(); pd_req_n = 1'b0;
    drive_slot(); pd_req_n = 1'b1;
    for (int k = 0; k < 12; k++) begin
      sample_slot();
      chk("R2", "osc_stop after glitch", 32'(osc_stop), 32'h0);
      chk("R2", "clk_out[0] after glitch", 32'(clk_out[0]), 32'h1);
    end

    // R6: global controls pass with two-edge latency
    drive_slot(); hiz_cfg = 1'b1; spread_cfg = 1'b1;
    sample_slot();
    chk("R6", "out_hiz after 1 edge", 32'(out_hiz), 32'h0);
    sample_slot();
    chk("R6", "out_hiz after 2 edges", 32'(out_hiz), 32'h1);
    chk("R6", "spread_en after 2 edges", 32'(spread_en), 32'h1);
    drive_slot(); hiz_cfg = 1'b0; spread_cfg = 1'b0;
    repeat (4) sample_slot();

    // R5: disabled output held low
    drive_slot(); out_en = 4'b1011;
    repeat (6) sample_slot();
    for (int k = 0; k < 8; k++) begin
      sample_slot();
      chk("R5", "clk_out[2] disabled", 32'(clk_out[2]), 32'h0);
    end
    drive_slot(); out_en = '1;
    repeat (8) sample_slot();

    // R3/R4: qualified power-down, drain, then stop request
    drive_slot(); pd_req_n = 1'b0;
    repeat (4) sample_slot();
    chk("R4", "osc_stop while draining", 32'(osc_stop), 32'h0);
    repeat (6) sample_slot();
    chk("R4", "osc_stop after drain", 32'(osc_stop), 32'h1);
    chk("R3", "clk_out parked", 32'(clk_out), 32'h0);
    repeat (10) sample_slot();

    // R4/R7: wake-up, settle count and ordered release
    drive_slot(); pd_req_n = 1'b1;
    repeat (3) sample_slot();
    chk("R4", "osc_stop before wake qual", 32'(osc_stop), 32'h1);
    sample_slot();
    chk("R4", "osc_stop after wake qual", 32'(osc_stop), 32'h0);
    for (int k = 0; k < 9; k++) begin
      sample_slot();
      chk("R7", "clk_out during settle", 32'(clk_out), 32'h0);
    end
    sample_slot();
    chk("R7", "clk_out[0] first released", 32'(clk_out[0]), 32'h1);
    chk("R7", "clk_out[3:1] not yet", 32'(clk_out[3:1]), 32'h0);
    repeat (20) sample_slot();

    // R8: power-down qualified in the middle of the release sequence
    drive_slot(); pd_req_n = 1'b0;
    repeat (20) sample_slot();
    drive_slot(); pd_req_n = 1'b1;
    repeat (10) drive_slot();
    pd_req_n = 1'b0;
    repeat (20) sample_slot();
    chk("R8", "osc_stop after abort", 32'(osc_stop), 32'h1);
    chk("R8", "clk_out after abort", 32'(clk_out), 32'h0);
    drive_slot(); pd_req_n = 1'b1;
    repeat (40) sample_slot();
    chk("R7", "clk_out[0] running after recovery", 32'(clk_out[0]), 32'h1);
    chk("R4", "osc_stop after recovery", 32'(osc_stop), 32'h0);
    finish_run();
  end

endmodule